// File: doc/BRIEF.md
# Jacobi Rotation Angle Unit

This block finds the angle of the plane rotation that zeroes the off-diagonal entry of a symmetric 2×2 sub-matrix taken from a larger matrix undergoing a two-sided Jacobi sweep. It takes the two diagonal entries and the shared off-diagonal entry as signed fixed-point words with 25 fraction bits. It builds the vector whose horizontal part is the difference of the diagonal entries (second minus first) and whose vertical part is twice the off-diagonal entry. A sequential shift-and-add vectoring engine then steers the vertical part toward zero, one micro-rotation per clock, and builds up the vector's angle as it goes. The unit halves that angle and returns it in the same fixed-point format.

A controller starts the unit once at the beginning of every Jacobi iteration with a single-cycle `start_i`. `busy_o` stays high until the result is ready. A single-cycle `done_o` then marks the cycle in which `angle_o` first holds the new value. The angle stays on `angle_o` until the next job completes, so the rotation units that follow can read it at their own pace. When the horizontal part is negative, the vector is mirrored through the origin and the angle register is preloaded with ±π. This lets the result cover the whole circle before halving, so it lands in [-π/2, π/2]. A zero off-diagonal entry skips the iterations altogether.

Top module: `jacobi_angle_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `angle_o` is zero.
- R2: When aqq − app ≥ 0 and apq ≠ 0, `angle_o` equals ½·atan2(2·apq, aqq − app) in radians, scaled by 2^25, to within 4362 LSB (about 1.3e-4 rad) after 14 micro-rotations.
- R3: When aqq − app < 0 and apq ≠ 0, the result still follows ½·atan2 over the full circle to the R2 tolerance, so angles with a magnitude above π/4 are produced.
- R4: When apq = 0, `angle_o` is exactly zero and `done_o` is high in the second cycle after the cycle in which `start_i` is accepted.
- R5: For apq ≠ 0, `done_o` is high in exactly the 17th cycle after `start_i` is accepted (ITERS + 3 with ITERS = 14), and it is high for one cycle only.
- R6: `busy_o` goes high in the cycle after an accepted start and stays high through the `done_o` cycle. A `start_i` seen while `busy_o` is high is ignored, and a job's result and latency do not depend on its inputs after the accepting cycle.
- R7: When 2·apq exceeds the signed 32-bit range, the vertical part saturates to 0x7FFFFFFF or 0x80000000 instead of wrapping, so the sign of the result follows the sign of apq.
- R8: `angle_o` never exceeds π/2 in magnitude, plus the R2 tolerance.
- R9: `angle_o` changes only in the cycle in which `done_o` rises, and it holds its value between jobs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Single-cycle request, accepted when `busy_o` is low |
| app_i | input | 32 | First diagonal entry, signed, 25 fraction bits |
| apq_i | input | 32 | Off-diagonal entry, signed, 25 fraction bits |
| aqq_i | input | 32 | Second diagonal entry, signed, 25 fraction bits |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle marker that `angle_o` has just been updated |
| angle_o | output | 32 | Half rotation angle in radians, signed, 25 fraction bits |

## Verification
Counting from the rising edge that accepts `start_i`, a zero off-diagonal job raises `done_o` after the second edge. Any other job raises it after the seventeenth edge: one operand-forming cycle, fourteen micro-rotations, one halving cycle and the edge into the done state. The bench counts rising edges from the accepting edge and samples `done_o` and `angle_o` on the falling edge after each one. It checks the edge count exactly, then checks that `done_o` drops one edge later. After that it checks that `angle_o` holds for several more cycles before the next job. For the start-while-busy case, a second request is issued partway through a job with different operands, and the bench checks that neither the count nor the angle changes.

// File: rtl/jacobi_angle_unit.sv
module jacobi_angle_unit #(
  parameter int W     = 32,
  parameter int ITERS = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic signed [W-1:0] app_i,
  input  logic signed [W-1:0] apq_i,
  input  logic signed [W-1:0] aqq_i,
  output logic                busy_o,
  output logic                done_o,
  output logic signed [W-1:0] angle_o
);
  localparam int FRAC = 25;
  localparam int XW   = W + 3;
  localparam int CW   = $clog2(ITERS + 1);
  localparam logic signed [W-1:0] PI_Q = W'(105414357);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_ITER, S_HALVE, S_DONE} state_t;

  function automatic logic signed [W-1:0] atan_step(input int i);
    case (i)
      0: atan_step = W'(26353589);
      1: atan_step = W'(15557433);
      2: atan_step = W'(8220120);
      3: atan_step = W'(4172661);
      4: atan_step = W'(2094428);
      5: atan_step = W'(1048235);
      6: atan_step = W'(524245);
      7: atan_step = W'(262139);
      8: atan_step = W'(131071);
      default: atan_step = (i <= FRAC) ? W'(64'sd1 <<< (FRAC - i)) : '0;
    endcase
  endfunction

  state_t               st_q;
  logic signed [W-1:0]  pp_q, pq_q, qq_q;
  logic signed [XW-1:0] x_q, y_q;
  logic signed [W-1:0]  z_q;
  logic [CW-1:0]        it_q;

  logic signed [W-1:0]  y2_sat;
  logic signed [XW-1:0] x0, y0, sh_x, sh_y;
  logic signed [W-1:0]  step_a;
  logic                 y_neg;

  assign y2_sat = (pq_q[W-1] != pq_q[W-2]) ? (pq_q[W-1] ? MINV : MAXV) : (pq_q <<< 1);
  assign x0     = XW'(qq_q) - XW'(pp_q);
  assign y0     = XW'(y2_sat);
  assign sh_x   = x_q >>> it_q;
  assign sh_y   = y_q >>> it_q;
  assign step_a = atan_step(int'(it_q));
  assign y_neg  = y_q[XW-1];

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      pp_q    <= '0;
      pq_q    <= '0;
      qq_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      it_q    <= '0;
      angle_o <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          pp_q <= app_i;
          pq_q <= apq_i;
          qq_q <= aqq_i;
          st_q <= S_PREP;
        end
        S_PREP: begin
          it_q <= '0;
          if (pq_q == '0) begin
            angle_o <= '0;
            st_q    <= S_DONE;
          end else begin
            if (x0[XW-1]) begin
              x_q <= -x0;
              y_q <= -y0;
              z_q <= y2_sat[W-1] ? -PI_Q : PI_Q;
            end else begin
              x_q <= x0;
              y_q <= y0;
              z_q <= '0;
            end
            st_q <= S_ITER;
          end
        end
        S_ITER: begin
          if (!y_neg) begin
            x_q <= x_q + sh_y;
            y_q <= y_q - sh_x;
            z_q <= z_q + step_a;
          end else begin
            x_q <= x_q - sh_y;
            y_q <= y_q + sh_x;
            z_q <= z_q - step_a;
          end
          it_q <= it_q + 1'b1;
          if (int'(it_q) == ITERS - 1) st_q <= S_HALVE;
        end
        S_HALVE: begin
          angle_o <= z_q >>> 1;
          st_q    <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

module jacobi_angle_unit_chk #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic signed [W-1:0] apq_i,
  input logic                busy_o,
  input logic                done_o,
  input logic signed [W-1:0] angle_o
);
  localparam logic signed [W-1:0] LIM = W'(52707179 + 4362);

  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);

  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  a_r6_busy_held: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);

  a_r4_zero_fast: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && apq_i == '0) |=> ##1 (done_o && angle_o == '0));

  a_r8_half_range: assert property (@(posedge clk) disable iff (rst)
    (angle_o <= LIM) && (angle_o >= -LIM));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(done_o) |-> $stable(angle_o));
endmodule

bind jacobi_angle_unit jacobi_angle_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .apq_i(apq_i),
  .busy_o(busy_o), .done_o(done_o), .angle_o(angle_o)
);

// File: tb/jacobi_angle_unit_tb_top.sv
`timescale 1ns/1ps
module jacobi_angle_unit_tb_top;
  localparam real SC  = 33554432.0;
  localparam real TOL = 1.3e-4;
  localparam real HPI = 1.5707963267948966;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [31:0] app = '0, apq = '0, aqq = '0;
  logic busy, done;
  logic signed [31:0] angle;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  jacobi_angle_unit dut_i (
    .clk(clk), .rst(rst), .start_i(start), .app_i(app), .apq_i(apq), .aqq_i(aqq),
    .busy_o(busy), .done_o(done), .angle_o(angle)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic real expect_angle(input logic signed [31:0] pp, pq, qq);
    real x, y;
    longint t;
    x = ($itor(qq) - $itor(pp)) / SC;
    t = 2 * longint'(pq);
    if (t > 64'sd2147483647) t = 64'sd2147483647;
    if (t < -64'sd2147483648) t = -64'sd2147483648;
    y = $itor(t) / SC;
    if (pq == 0) return 0.0;
    return $atan2(y, x) / 2.0;
  endfunction

  task automatic run_op(input logic signed [31:0] pp, pq, qq, input bit poke, output int lat);
    @(negedge clk);
    app = pp; apq = pq; aqq = qq; start = 1'b1;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      app = 32'sh0123_4567; apq = -32'sd7777777; aqq = 32'sh0F00_0000;
      if (poke && lat == 5) start = 1'b1;
    end while (!done && lat < 60);
  endtask

  task automatic do_case(input real rp, rq, rr, input bit poke);
    logic signed [31:0] pp, pq, qq, held;
    int lat, want;
    real exp_a, got, err;
    string req;
    pp = $rtoi(rp * SC); pq = $rtoi(rq * SC); qq = $rtoi(rr * SC);
    run_op(pp, pq, qq, poke, lat);
    exp_a = expect_angle(pp, pq, qq);
    got = $itor(angle) / SC;
    err = (got > exp_a) ? got - exp_a : exp_a - got;
    want = (pq == 0) ? 2 : 17;
    if (pq == 0) begin
      check(lat == 2, "R4", $sformatf("latency got %0d exp 2", lat));
      check(angle == 0, "R4", $sformatf("angle got %0d exp 0", angle));
    end else begin
      req = poke ? "R6" : (abs_big(rq) ? "R7" : ((rr - rp) < 0.0 ? "R3" : "R2"));
      check(lat == want, "R5", $sformatf("latency got %0d exp %0d", lat, want));
      check(err <= TOL, req, $sformatf("angle got %f exp %f (pp=%f pq=%f qq=%f)",
            got, exp_a, rp, rq, rr));
    end
    check(got <= HPI + TOL && got >= -HPI - TOL, "R8", $sformatf("range got %f exp |a|<=%f", got, HPI));
    held = angle;
    @(negedge clk);
    check(!done, "R5", $sformatf("done width got %0b exp 0", done));
    check(!busy, "R6", $sformatf("busy after done got %0b exp 0", busy));
    repeat (3) @(negedge clk);
    check(angle == held, "R9", $sformatf("hold got %0d exp %0d", angle, held));
  endtask

  function automatic bit abs_big(input real v);
    return (v > 32.0) || (v < -32.0);
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    real vals [7] = '{-3.0, -1.0, -0.25, 0.0, 0.5, 2.0, 5.0};
    int lat;
    repeat (3) @(negedge clk);
    check(!busy && !done && angle == 0, "R1",
          $sformatf("reset busy=%0b done=%0b angle=%0d exp 0 0 0", busy, done, angle));
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done, "R1", $sformatf("idle busy=%0b done=%0b exp 0 0", busy, done));

    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++)
          do_case(vals[a], vals[b], vals[c], 1'b0);

    // R7: saturation of the doubled off-diagonal entry
    do_case(0.0, 40.0, 1.0, 1'b0);
    do_case(0.0, -40.0, 1.0, 1'b0);
    do_case(10.0, 63.9, -10.0, 1'b0);
    do_case(0.0, -64.0, 0.0, 1'b0);
    // R3: strongly negative horizontal part, near the ±π fold
    do_case(20.0, 0.01, -20.0, 1'b0);
    do_case(20.0, -0.01, -20.0, 1'b0);
    // R6: start during busy is ignored
    do_case(1.0, 0.75, -2.0, 1'b1);
    do_case(-0.5, -1.5, 3.0, 1'b1);

    @(negedge clk);
    start = 1'b1; app = 0; apq = $rtoi(1.0 * SC); aqq = 0;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R6", $sformatf("busy after start got %0b exp 1", busy));
    lat = 0;
    while (!done && lat < 60) begin @(negedge clk); lat++; end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule